// File: doc/BRIEF.md
# Serial-in descending sort engine

This block gathers a fixed batch of ten signed 8-bit samples, one per strobed cycle, into a small internal word store. It then orders them from largest to smallest and streams the ordered batch back out. Samples enter on `din` in any cycle where `din_en` is high. Idle cycles between samples are allowed. Once the tenth sample is captured, the engine sorts the store in place and accepts nothing further until the batch has left.

Sorting is a bubble pass structure over adjacent pairs. Each pass is one pair shorter than the pass before it. Sorting stops after a pass that exchanged nothing, or after the ninth pass at the latest. An exchange goes through a spare word of the store: the upper element is copied aside, the lower element moves up, and the saved copy moves down. Each of these three writes takes its own clock cycle. The ordered values then leave on ten back-to-back cycles, each marked by `dout_rdy`, and the engine returns to collecting a new batch.

Top module: `desc_sort_engine`

## Requirements
- R1: A sample is captured only on a rising clock edge where `din_en` is high while the engine is collecting. Exactly ten captures make a batch, and idle cycles between captures are allowed.
- R2: Samples are 8-bit two's-complement values (0x80 is -128, 0x7F is +127), and all ordering decisions use signed magnitude.
- R3: The ten output values are the captured batch in non-increasing signed order, largest first.
- R4: Each exchange of two elements takes three consecutive cycles of store writes, after the one-cycle comparison that found the pair out of order. A comparison that needs no exchange takes one cycle.
- R5: Pass p (counting from 0) compares pairs (0,1) up to (8-p,9-p). Sorting ends after the first pass without an exchange, or after pass 8. With C comparisons and W exchanges in total, `dout_rdy` first rises C+3W+1 clock edges after the edge that captured the tenth sample.
- R6: `dout_rdy` is high for exactly ten consecutive cycles per batch, one value per cycle, and low otherwise.
- R7: `din_en` pulses and `din` values presented while sorting or emitting have no effect on the batch being output.
- R8: After the tenth output the engine is collecting again, and a new batch may start in the very next cycle.
- R9: While `rst` is high and after its release, `dout_rdy` is 0, `dout` is 0 and the engine is collecting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Signed input sample |
| din_en | input | 1 | Qualifies `din` for capture |
| dout | output | 8 | Signed sorted output value |
| dout_rdy | output | 1 | Marks a valid `dout` value |

## Verification
A corrupted index, pass counter or exchange flag in this block shows up at the ports in one of two ways. Either an output value leaves its place in the descending sequence, or the first `dout_rdy` arrives off the cycle count predicted from the comparisons and exchanges. Both show within one batch. The bench checks the exact start cycle against an independent model of the pass structure, so one extra or missing exchange cycle, or one pass too many or too few, is caught before the first value leaves. A bad emission counter shows as a burst longer or shorter than ten cycles. A capture that leaks in while the engine is busy shows as a wrong value in the batch that is being output.

// File: rtl/dsort_pkg.sv
package dsort_pkg;
   typedef enum logic [2:0] {
      ST_LOAD,
      ST_CMP,
      ST_SW1,
      ST_SW2,
      ST_SW3,
      ST_EMIT
   } dsort_state_e;
endpackage

// File: rtl/dsort_store.sv
// Word store: one synchronous write port, two combinational read ports.
module dsort_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 11,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     ra_addr,
   input  logic [AW-1:0]     rb_addr,
   output logic [DATA_W-1:0] ra_data,
   output logic [DATA_W-1:0] rb_data
);
   localparam int SLOTS = 1 << AW;

   logic [SLOTS*DATA_W-1:0] flat;

   if (DEPTH < 2 || DEPTH > SLOTS) begin : g_bad_depth
      $error("dsort_store: DEPTH out of range for AW");
   end

   for (genvar g = 0; g < SLOTS; g++) begin : g_word
      if (g < DEPTH) begin : g_live
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (we && waddr == AW'(g)) q <= wdata;
         end
         assign flat[g*DATA_W +: DATA_W] = q;
      end else begin : g_pad
         assign flat[g*DATA_W +: DATA_W] = '0;
      end
   end

   assign ra_data = flat[int'(ra_addr)*DATA_W +: DATA_W];
   assign rb_data = flat[int'(rb_addr)*DATA_W +: DATA_W];
endmodule

// File: rtl/dsort_ctrl.sv
// Sequencer: collect, bubble passes with three-write exchange, emit.
module dsort_ctrl
   import dsort_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int COUNT  = 10,
   parameter int AW     = $clog2(COUNT + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] din,
   input  logic              din_en,
   input  logic [DATA_W-1:0] ra_data,
   input  logic [DATA_W-1:0] rb_data,
   output logic              mem_we,
   output logic [AW-1:0]     mem_waddr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [AW-1:0]     ra_addr,
   output logic [AW-1:0]     rb_addr,
   output logic [DATA_W-1:0] dout,
   output logic              dout_rdy
);
   localparam logic [AW-1:0] TEMP = AW'(COUNT);
   localparam logic [AW-1:0] LAST = AW'(COUNT - 1);
   localparam logic [AW-1:0] MAXP = AW'(COUNT - 2);

   dsort_state_e  state;
   logic [AW-1:0] cnt, j, pass;
   logic          swapped;
   logic          less, j_last, saw, step, done_sort;

   always_comb begin
      less      = $signed(ra_data) < $signed(rb_data);
      j_last    = (j == (MAXP - pass));
      saw       = swapped | (state == ST_SW3);
      step      = (state == ST_CMP && !less) || (state == ST_SW3);
      done_sort = j_last && (!saw || pass == MAXP);
   end

   always_comb begin
      ra_addr   = j;
      rb_addr   = j + AW'(1);
      mem_we    = 1'b0;
      mem_waddr = cnt;
      mem_wdata = din;
      case (state)
         ST_LOAD: mem_we = din_en;
         ST_SW1: begin
            mem_we    = 1'b1;
            mem_waddr = TEMP;
            mem_wdata = ra_data;
         end
         ST_SW2: begin
            mem_we    = 1'b1;
            mem_waddr = j;
            mem_wdata = rb_data;
         end
         ST_SW3: begin
            ra_addr   = TEMP;
            mem_we    = 1'b1;
            mem_waddr = j + AW'(1);
            mem_wdata = ra_data;
         end
         ST_EMIT: ra_addr = cnt;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_LOAD;
         cnt      <= '0;
         j        <= '0;
         pass     <= '0;
         swapped  <= 1'b0;
         dout     <= '0;
         dout_rdy <= 1'b0;
      end else begin
         dout_rdy <= 1'b0;
         case (state)
            ST_LOAD: if (din_en) begin
               if (cnt == LAST) begin
                  cnt     <= '0;
                  j       <= '0;
                  pass    <= '0;
                  swapped <= 1'b0;
                  state   <= ST_CMP;
               end else begin
                  cnt <= cnt + AW'(1);
               end
            end
            ST_CMP:  if (less) state <= ST_SW1;
            ST_SW1:  state <= ST_SW2;
            ST_SW2:  state <= ST_SW3;
            ST_EMIT: begin
               dout     <= ra_data;
               dout_rdy <= 1'b1;
               if (cnt == LAST) begin
                  cnt   <= '0;
                  state <= ST_LOAD;
               end else begin
                  cnt <= cnt + AW'(1);
               end
            end
            default: ;
         endcase
         if (step) begin
            if (done_sort) begin
               cnt   <= '0;
               state <= ST_EMIT;
            end else if (j_last) begin
               pass    <= pass + AW'(1);
               j       <= '0;
               swapped <= 1'b0;
               state   <= ST_CMP;
            end else begin
               j       <= j + AW'(1);
               swapped <= saw;
               state   <= ST_CMP;
            end
         end
      end
   end

   // ---- checks next to the logic they guard ----
   logic [AW-1:0] run;
   always_ff @(posedge clk) begin
      if (rst) run <= '0;
      else     run <= dout_rdy ? run + AW'(1) : '0;
   end

   a_r3_desc_order: assert property (@(posedge clk) disable iff (rst)
      (dout_rdy && $past(dout_rdy)) |-> ($signed(dout) <= $signed($past(dout))));
   a_r4_swap_first: assert property (@(posedge clk) disable iff (rst)
      (state == ST_SW1) |=> (state == ST_SW2));
   a_r4_swap_second: assert property (@(posedge clk) disable iff (rst)
      (state == ST_SW2) |=> (state == ST_SW3));
   a_r5_pass_bound: assert property (@(posedge clk) disable iff (rst)
      pass <= MAXP);
   a_r6_burst_len: assert property (@(posedge clk) disable iff (rst)
      $fell(dout_rdy) |-> (run == AW'(COUNT)));
   a_r7_no_write_busy: assert property (@(posedge clk) disable iff (rst)
      (state == ST_CMP || state == ST_EMIT) |-> !mem_we);
endmodule

// File: rtl/desc_sort_engine.sv
module desc_sort_engine #(
   parameter int DATA_W = 8,
   parameter int COUNT  = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] din,
   input  logic              din_en,
   output logic [DATA_W-1:0] dout,
   output logic              dout_rdy
);
   localparam int DEPTH = COUNT + 1;
   localparam int AW    = $clog2(DEPTH);

   if (COUNT < 2 || DATA_W < 2) begin : g_bad_param
      $error("desc_sort_engine: COUNT and DATA_W must be at least 2");
   end

   logic              mem_we;
   logic [AW-1:0]     mem_waddr, ra_addr, rb_addr;
   logic [DATA_W-1:0] mem_wdata, ra_data, rb_data;

   dsort_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
      .clk     (clk),
      .we      (mem_we),
      .waddr   (mem_waddr),
      .wdata   (mem_wdata),
      .ra_addr (ra_addr),
      .rb_addr (rb_addr),
      .ra_data (ra_data),
      .rb_data (rb_data)
   );

   dsort_ctrl #(.DATA_W(DATA_W), .COUNT(COUNT), .AW(AW)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .din       (din),
      .din_en    (din_en),
      .ra_data   (ra_data),
      .rb_data   (rb_data),
      .mem_we    (mem_we),
      .mem_waddr (mem_waddr),
      .mem_wdata (mem_wdata),
      .ra_addr   (ra_addr),
      .rb_addr   (rb_addr),
      .dout      (dout),
      .dout_rdy  (dout_rdy)
   );
endmodule

// File: tb/desc_sort_engine_tb.sv
module desc_sort_engine_tb;
   localparam int N = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] din = '0;
   logic       din_en = 1'b0;
   logic [7:0] dout;
   logic       dout_rdy;

   int checks = 0;
   int fails  = 0;
   int vals  [N];
   int exp_s [N];
   int cmp_n, swp_n;

   always #2 clk = ~clk;

   desc_sort_engine u_dut (
      .clk(clk), .rst(rst), .din(din), .din_en(din_en),
      .dout(dout), .dout_rdy(dout_rdy)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Bubble passes with early stop, counting comparisons and exchanges (R5).
   function automatic void model();
      int a [N];
      for (int k = 0; k < N; k++) a[k] = vals[k];
      cmp_n = 0;
      swp_n = 0;
      for (int p = 0; p <= N - 2; p++) begin
         bit sw = 1'b0;
         for (int q = 0; q <= N - 2 - p; q++) begin
            cmp_n++;
            if (a[q] < a[q+1]) begin
               int t = a[q];
               a[q] = a[q+1];
               a[q+1] = t;
               swp_n++;
               sw = 1'b1;
            end
         end
         if (!sw) break;
      end
      for (int k = 0; k < N; k++) exp_s[k] = a[k];
   endfunction

   task automatic run_case(input int gap_max, input bit junk, input string tag);
      int lat;
      model();
      for (int k = 0; k < N; k++) begin
         int g = (gap_max > 0) ? int'($urandom_range(0, gap_max)) : 0;
         repeat (g) begin
            din_en = 1'b0;
            din = 8'($urandom);
            @(negedge clk);
         end
         din_en = 1'b1;
         din = 8'(vals[k]);
         @(negedge clk);
      end
      lat = 1;
      while (!dout_rdy && lat < 1000) begin
         din_en = junk;
         din = 8'($urandom);
         @(negedge clk);
         lat++;
      end
      // first out edge = C+3W+1 edges after capture edge, seen C+3W+2 negedges on
      chk(lat == cmp_n + 3*swp_n + 2, {"R4 R5 R8 start cycle ", tag}, lat, cmp_n + 3*swp_n + 2);
      for (int k = 0; k < N; k++) begin
         chk(dout_rdy == 1'b1, {"R6 ready per value ", tag}, int'(dout_rdy), 1);
         chk(int'($signed(dout)) == exp_s[k], {"R1 R2 R3 R7 value ", tag},
             int'($signed(dout)), exp_s[k]);
         din_en = junk && (k < N - 1);
         din = 8'($urandom);
         @(negedge clk);
      end
      din_en = 1'b0;
      chk(dout_rdy == 1'b0, {"R6 burst ends ", tag}, int'(dout_rdy), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(dout_rdy == 1'b0, "R9 ready in reset", int'(dout_rdy), 0);
      rst = 1'b0;
      @(negedge clk);
      chk(dout_rdy == 1'b0, "R9 ready after reset", int'(dout_rdy), 0);
      chk(dout == 8'h00, "R9 data after reset", int'(dout), 0);

      // already descending: single pass, early stop
      for (int k = 0; k < N; k++) vals[k] = 100 - 10*k;
      run_case(0, 1'b0, "descending");
      // ascending: every comparison exchanges, all passes
      for (int k = 0; k < N; k++) vals[k] = -5 + k;
      run_case(0, 1'b0, "ascending");
      // all equal: no exchange
      for (int k = 0; k < N; k++) vals[k] = 7;
      run_case(0, 1'b0, "equal");
      // signed extremes and duplicates, busy-time strobes present
      vals = '{127, -128, 0, -1, 1, 127, -128, 64, -64, 0};
      run_case(2, 1'b1, "extremes");

      for (int r = 0; r < 24; r++) begin
         for (int k = 0; k < N; k++) begin
            logic signed [7:0] b = 8'($urandom);
            vals[k] = int'(b);
         end
         run_case((r % 3 == 0) ? 3 : 0, r[0], "random");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule